// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block acts as the memory side of a two-wire serial bus. It runs entirely on a fast system clock. The incoming clock and data lines are oversampled, and the data line is pulled low through an open-drain enable. The block never drives the data line high.

A controller addresses the block with a control byte. That byte carries the fixed device-type code `1010`, three chip-select bits that must equal the strap inputs, and a direction bit. After the control byte come a high and a low address byte. Together they form a 13-bit word address.

- **Byte write:** one data byte follows the address and is stored once its acknowledge completes.
- **Random read:** the controller issues a repeated start and a read control byte. The block then shifts out one byte, most significant bit first.
- **Current-address read:** a read control byte right after a plain start returns the byte at the internal pointer. The pointer advances after every read.

The byte array is small. Its depth is set by a parameter, and it is indexed by the low bits of the 13-bit address. A write-protect input turns the array into read-only storage.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A falling SDA while SCL is high is a start and a rising SDA while SCL is high is a stop. After a stop the block stays idle and does not acknowledge clocked bytes until a new start.
- R2: SDA is only ever pulled low (`sda_pull_low` = 1 means pull low). The pull-down never changes while SCL is high.
- R3: A control byte is accepted only if bits 7..4 are 1010 and bits 3..1 equal `strap_sel`. Bit 0 = 0 selects write and bit 0 = 1 selects read. An accepted control byte is acknowledged on the ninth clock. A rejected one is not, and the rest of that transaction is ignored.
- R4: The two bytes after a write control byte form the address as {high[4:0], low}. High bits 7..5 are ignored, and each address byte is acknowledged.
- R5: The data byte after the address is acknowledged and stored at that address once the acknowledge clock ends.
- R6: With `wr_protect` = 1 the data byte gets no acknowledge and the array is unchanged. Reads still work.
- R7: After a repeated start and an accepted read control byte, the block acknowledges and shifts the addressed byte out MSB first, one bit per SCL high phase.
- R8: A start or stop inside a byte aborts the transaction without a write. After an abort by start, a fresh control byte is accepted.
- R9: Every read advances the pointer by one, wrapping from 8191 to 0. A read control byte right after a plain start returns the byte at the pointer.
- R10: After reset the array reads as zero and SDA is released.
- R11: The array holds 2^MEM_AW bytes (64 by default) indexed by address bits MEM_AW-1..0, so addresses 64 apart alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_sel | input | 3 | Chip-select straps compared with control byte bits 3..1 |
| wr_protect | input | 1 | 1 = array is read-only |
| sda_pull_low | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
Every pull-down change follows an SCL fall by three system cycles: two synchronizer flops plus the registered enable. Acknowledges and read bits therefore sit on the bus well before the next SCL rise, and the bench samples SDA eight cycles into each high phase. A write reaches the array on the cycle the acknowledge clock's fall is seen, so the bench reads it back only after a stop and a new transaction. A per-clock monitor flags any pull-down during controller-driven bits, from four cycles after SCL falls. A second monitor flags any pull-down change while the controller holds SCL high.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  localparam int PTR_W = 13;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_ACK, PH_TX} phase_t;
  typedef enum logic [1:0] {SG_CTRL, SG_AHI, SG_ALO, SG_DATA} stage_t;

  // Control byte selects this target when code and straps agree.
  function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_CODE) && (b[3:1] == strap);
  endfunction

  // Pointer step with wrap at the top of the 13-bit space.
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == {PTR_W{1'b1}}) ? '0 : p + 1'b1;
  endfunction

  // Word address from the kept high bits and the low byte.
  function automatic logic [PTR_W-1:0] join_addr(input logic [PTR_W-9:0] hi,
                                                 input logic [7:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_byte_array.sv
module eeprom_byte_array #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int MEM_AW = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_sel,
  input  logic       wr_protect,
  output logic       sda_pull_low
);
  localparam int HI_W = PTR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  phase_t phase;
  stage_t stage;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg, wbuf;
  logic [HI_W-1:0] addr_hi;
  logic [PTR_W-1:0] rd_ptr;
  logic do_read, do_commit;
  logic [7:0] rd_data;

  // Named internal events for the checker.
  logic ev_byte_done, ev_ctrl_miss, ev_data_byte, ev_tx_done, mem_we, phase_idle;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign ev_byte_done = (phase == PH_RX) && scl_fall && (bitcnt == 4'd8);
  assign ev_ctrl_miss = ev_byte_done && (stage == SG_CTRL) && !ctrl_hit(shreg, strap_sel);
  assign ev_data_byte = ev_byte_done && (stage == SG_DATA);
  assign ev_tx_done   = (phase == PH_TX) && scl_fall && (bitcnt == 4'd7);
  assign mem_we       = (phase == PH_ACK) && scl_fall && do_commit;
  assign phase_idle   = (phase == PH_IDLE);

  eeprom_byte_array #(.AW(MEM_AW)) array_i (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(rd_ptr[MEM_AW-1:0]),
    .wdata(wbuf), .raddr(rd_ptr[MEM_AW-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= PH_IDLE;
      stage        <= SG_CTRL;
      bitcnt       <= '0;
      shreg        <= '0;
      txreg        <= '0;
      wbuf         <= '0;
      addr_hi      <= '0;
      rd_ptr       <= '0;
      do_read      <= 1'b0;
      do_commit    <= 1'b0;
      sda_pull_low <= 1'b0;
    end else if (start_det) begin
      phase        <= PH_RX;
      stage        <= SG_CTRL;
      bitcnt       <= '0;
      do_read      <= 1'b0;
      do_commit    <= 1'b0;
      sda_pull_low <= 1'b0;
    end else if (stop_det) begin
      phase        <= PH_IDLE;
      do_read      <= 1'b0;
      do_commit    <= 1'b0;
      sda_pull_low <= 1'b0;
    end else begin
      unique case (phase)
        PH_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (ev_byte_done) begin
            bitcnt <= '0;
            phase  <= PH_ACK;
            sda_pull_low <= 1'b1;
            unique case (stage)
              SG_CTRL: begin
                if (!ctrl_hit(shreg, strap_sel)) begin
                  phase <= PH_IDLE;
                  sda_pull_low <= 1'b0;
                end else if (shreg[0]) begin
                  do_read <= 1'b1;
                  txreg   <= rd_data;
                end else begin
                  stage <= SG_AHI;
                end
              end
              SG_AHI: begin
                addr_hi <= shreg[HI_W-1:0];
                stage   <= SG_ALO;
              end
              SG_ALO: begin
                rd_ptr <= join_addr(addr_hi, shreg);
                stage  <= SG_DATA;
              end
              default: begin
                if (wr_protect) begin
                  phase <= PH_IDLE;
                  sda_pull_low <= 1'b0;
                end else begin
                  wbuf      <= shreg;
                  do_commit <= 1'b1;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (do_read) begin
              phase        <= PH_TX;
              do_read      <= 1'b0;
              sda_pull_low <= ~txreg[7];
            end else if (do_commit) begin
              phase        <= PH_IDLE;
              do_commit    <= 1'b0;
              sda_pull_low <= 1'b0;
            end else begin
              phase        <= PH_RX;
              sda_pull_low <= 1'b0;
            end
          end
        end
        PH_TX: begin
          if (ev_tx_done) begin
            phase        <= PH_IDLE;
            sda_pull_low <= 1'b0;
            rd_ptr       <= ptr_step(rd_ptr);
          end else if (scl_fall) begin
            txreg        <= {txreg[6:0], 1'b0};
            sda_pull_low <= ~txreg[6];
            bitcnt       <= bitcnt + 4'd1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        start_det,
  input logic        stop_det,
  input logic        sda_pull_low,
  input logic        phase_idle,
  input logic        ev_ctrl_miss,
  input logic        ev_data_byte,
  input logic        wr_protect,
  input logic        mem_we,
  input logic        ev_tx_done,
  input logic [12:0] rd_ptr
);
  a_r2_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_low));

  a_r1_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase_idle && !sda_pull_low));

  a_r3_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_miss |=> (!sda_pull_low && phase_idle));

  a_r6_protect_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_byte && wr_protect) |=> !sda_pull_low);

  a_r5_commit_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> sda_pull_low);

  a_r8_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_low);

  a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_done && rd_ptr == 13'h1FFF) |=> (rd_ptr == 13'h0000));
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull_low(sda_pull_low), .phase_idle(phase_idle),
  .ev_ctrl_miss(ev_ctrl_miss), .ev_data_byte(ev_data_byte),
  .wr_protect(wr_protect), .mem_we(mem_we), .ev_tx_done(ev_tx_done),
  .rd_ptr(rd_ptr)
);

// File: tb/eeprom_i2c_target_tb_top.sv
module eeprom_i2c_target_tb_top;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_o = 1'b1;
  logic sda_o = 1'b1;
  logic [2:0] strap = 3'b000;
  logic wp = 1'b0;
  logic pull;
  wire  sda_bus = sda_o & ~pull;

  int tests = 0;
  int fails = 0;
  bit quiet = 1'b0;
  string qtag = "R3";
  logic pull_prev = 1'b0;
  bit finished = 1'b0;

  int mem_m [64];
  int ptr_m = 0;

  always #2.5 clk = ~clk;

  eeprom_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_o), .sda_in(sda_bus),
    .strap_sel(strap), .wr_protect(wp), .sda_pull_low(pull)
  );

  // Per-clock monitors.
  always @(negedge clk) begin
    if (rst_n) begin
      if (quiet && pull) begin
        fails++;
        $display("FAIL %s: pull-down during controller bit, actual=1 expected=0", qtag);
      end
      if ((pull !== pull_prev) && scl_o) begin
        fails++;
        $display("FAIL R2: pull-down changed with SCL high, actual=%0b expected=%0b", pull, pull_prev);
      end
      pull_prev = pull;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input logic q, output logic s);
    wcyc(4); sda_o = b; quiet = q;
    wcyc(Q - 4); scl_o = 1'b1;
    wcyc(Q / 2); s = sda_bus;
    wcyc(Q / 2); scl_o = 1'b0; quiet = 1'b0;
  endtask

  task automatic bus_start();
    wcyc(4); sda_o = 1'b1; wcyc(Q); scl_o = 1'b1; wcyc(Q);
    sda_o = 1'b0; wcyc(Q); scl_o = 1'b0;
  endtask

  task automatic bus_stop();
    wcyc(4); sda_o = 1'b0; wcyc(Q); scl_o = 1'b1; wcyc(Q);
    sda_o = 1'b1; wcyc(Q);
  endtask

  task automatic xfer(input logic [7:0] b, input logic q, output logic [7:0] got,
                      output logic acked);
    logic s;
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      send_bit(b[i], q, s);
      got = {got[6:0], s};
    end
    send_bit(1'b1, 1'b0, s);
    acked = !s;
  endtask

  task automatic write_txn(input logic [7:0] ctrl, input logic [15:0] a,
                           input logic [7:0] d, output logic [3:0] acks);
    logic [7:0] g;
    bus_start();
    xfer(ctrl, 1'b1, g, acks[3]);
    xfer(a[15:8], 1'b1, g, acks[2]);
    xfer(a[7:0], 1'b1, g, acks[1]);
    xfer(d, 1'b1, g, acks[0]);
    bus_stop();
  endtask

  task automatic read_txn(input logic [2:0] dev, input logic [15:0] a,
                          output logic [7:0] d, output logic [3:0] acks);
    logic [7:0] g;
    logic na;
    bus_start();
    xfer({4'b1010, dev, 1'b0}, 1'b1, g, acks[3]);
    xfer(a[15:8], 1'b1, g, acks[2]);
    xfer(a[7:0], 1'b1, g, acks[1]);
    bus_start();
    xfer({4'b1010, dev, 1'b1}, 1'b1, g, acks[0]);
    xfer(8'hFF, 1'b0, d, na);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d, output logic ack);
    logic [7:0] g;
    logic na;
    bus_start();
    xfer(8'hA1, 1'b1, g, ack);
    xfer(8'hFF, 1'b0, d, na);
    bus_stop();
  endtask

  // Reference model helpers.
  task automatic m_write(input int a, input int d);
    mem_m[a % 64] = d;
  endtask

  task automatic m_read(input int a, output int d);
    d = mem_m[a % 64];
    ptr_m = ((a % 8192) + 1) % 8192;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] acks;
    logic [7:0] d, g;
    logic a1, s;
    int e;
    for (int i = 0; i < 64; i++) mem_m[i] = 0;

    wcyc(10); rst_n = 1'b1; wcyc(10);
    chk("R10 pull released after reset", int'(pull), 0);
    read_txn(3'b000, 16'h0003, d, acks);
    m_read(3, e);
    chk("R10 array reads zero", int'(d), e);

    // R5 / R3 / R4 byte write
    write_txn(8'hA0, 16'h0005, 8'hA5, acks);
    m_write(5, 8'hA5);
    chk("R3 R4 R5 write acks", int'(acks), 4'b1111);
    read_txn(3'b000, 16'h0005, d, acks);
    m_read(5, e);
    chk("R7 random read acks", int'(acks), 4'b1111);
    chk("R7 random read data", int'(d), e);

    // R9 current-address read follows the pointer
    write_txn(8'hA0, 16'h0006, 8'h66, acks);
    m_write(6, 8'h66);
    read_txn(3'b000, 16'h0005, d, acks);
    m_read(5, e);
    cur_read(d, a1);
    m_read(ptr_m, e);
    chk("R9 current read ack", int'(a1), 1);
    chk("R9 current read data", int'(d), e);

    // R4 high bits 7..5 ignored
    write_txn(8'hA0, 16'hE007, 8'h3C, acks);
    m_write(7, 8'h3C);
    read_txn(3'b000, 16'h0007, d, acks);
    m_read(7, e);
    chk("R4 top bits ignored", int'(d), e);

    // R3 mismatched straps and code
    qtag = "R3";
    write_txn(8'hA2, 16'h0005, 8'h11, acks);
    chk("R3 strap mismatch no ack", int'(acks), 4'b0000);
    write_txn(8'hB0, 16'h0005, 8'h22, acks);
    chk("R3 code mismatch no ack", int'(acks), 4'b0000);
    read_txn(3'b000, 16'h0005, d, acks);
    m_read(5, e);
    chk("R3 array untouched", int'(d), e);

    // R3 other strap value
    strap = 3'b101;
    write_txn(8'hAA, 16'h0008, 8'h81, acks);
    m_write(8, 8'h81);
    chk("R3 strap 101 acks", int'(acks), 4'b1111);
    strap = 3'b000;
    read_txn(3'b000, 16'h0008, d, acks);
    m_read(8, e);
    chk("R3 strap 101 data", int'(d), e);

    // R6 write protect
    wp = 1'b1;
    write_txn(8'hA0, 16'h0005, 8'h11, acks);
    chk("R6 data byte not acked", int'(acks), 4'b1110);
    read_txn(3'b000, 16'h0005, d, acks);
    m_read(5, e);
    chk("R6 array unchanged, read allowed", int'(d), e);
    wp = 1'b0;

    // R8 abort by stop inside the data byte
    bus_start();
    xfer(8'hA0, 1'b1, g, a1);
    xfer(8'h00, 1'b1, g, a1);
    xfer(8'h09, 1'b1, g, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1, s);
    bus_stop();
    read_txn(3'b000, 16'h0009, d, acks);
    m_read(9, e);
    chk("R8 stop abort no write", int'(d), e);

    // R8 abort by start inside the data byte
    bus_start();
    xfer(8'hA0, 1'b1, g, a1);
    xfer(8'h00, 1'b1, g, a1);
    xfer(8'h0A, 1'b1, g, a1);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1, s);
    bus_start();
    xfer(8'hA0, 1'b1, g, a1);
    chk("R8 fresh control acked after abort", int'(a1), 1);
    bus_stop();
    read_txn(3'b000, 16'h000A, d, acks);
    m_read(10, e);
    chk("R8 start abort no write", int'(d), e);

    // R1 bytes clocked without a start are ignored
    scl_o = 1'b0;
    wcyc(Q);
    qtag = "R1";
    xfer(8'hA0, 1'b1, g, a1);
    chk("R1 no ack without start", int'(a1), 0);
    bus_stop();

    // R9 pointer wrap at 8191
    write_txn(8'hA0, 16'h1FFF, 8'h77, acks);
    m_write(8191, 8'h77);
    write_txn(8'hA0, 16'h0000, 8'h12, acks);
    m_write(0, 8'h12);
    read_txn(3'b000, 16'h1FFF, d, acks);
    m_read(8191, e);
    chk("R9 read at 8191", int'(d), e);
    cur_read(d, a1);
    m_read(ptr_m, e);
    chk("R9 pointer wrapped to 0", int'(d), e);

    // R11 aliasing of addresses 64 apart
    write_txn(8'hA0, 16'h0041, 8'h5A, acks);
    m_write(65, 8'h5A);
    read_txn(3'b000, 16'h0001, d, acks);
    m_read(1, e);
    chk("R11 alias read", int'(d), e);

    tests += 2; // R2 and quiet-window monitors
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule